// File: doc/BRIEF.md
# Command Stream Method Decoder

This block turns a buffer of 32-bit command words into a sequence of register writes. Each write carries a method number, a subchannel and a 32-bit value. A one-cycle `start` pulse, taken while the block is idle, latches the buffer length in words. The words then arrive on a valid/ready input. Every packet begins with a header word. The header selects how the method number advances across the argument words that follow it, or it carries a 13-bit immediate value for a single write.

The writes leave on a valid/ready output. Argument words pass straight through from input to output, so one accepted argument word produces one accepted write. A single-cycle `done` pulse marks a buffer that was consumed cleanly. Malformed content raises one of three error pulses: an unknown mode, a zero-length increase-once packet, or a buffer that ends in the middle of a packet.

Top module: `cmd_method_decoder`

## Requirements
- R1: A header word is split as method = bits 12:0, subchannel = bits 15:13, argument count = bits 28:16 and mode = bits 31:29. Every write of the packet carries that subchannel.
- R2: In modes 0 and 1, argument i (counted from 0) is written to method (header method + i) modulo 8192, carrying the argument word as its value.
- R3: In modes 2 and 3, every argument is written to the header method.
- R4: In mode 4, no argument words follow the header. Exactly one write is issued to the header method, with value = bits 28:16 of the header, zero-extended to 32 bits.
- R5: In mode 5 with a count of at least 1, the first argument goes to the header method and every later argument goes to (header method + 1) modulo 8192.
- R6: A packet in modes 0 to 3 with a count of 0 issues no write, and the next word is parsed as a header.
- R7: A mode-5 header with a count of 0 pulses `err_count` for one cycle, in the cycle that header is accepted. It issues no write, and parsing continues with the next word as a header.
- R8: A header in mode 6 or 7 pulses `err_mode` in the cycle it is accepted. The block then returns to idle, consumes no further words and gives no `done`.
- R9: If the consumed word count reaches the buffer length while arguments are still owed, `err_trunc` pulses for one cycle and the block returns to idle without `done`. The block never accepts more words than the buffer length.
- R10: Once the buffer length has been consumed and the last write accepted, `done` pulses for exactly one cycle and `busy` falls in the next cycle. A length of 0 gives `done` with no write.
- R11: After reset, and whenever idle, `in_ready`, `out_valid`, `busy` and `done` are low, and a `start` pulse begins a buffer.
- R12: While `out_valid` is high and `out_ready` is low, the pending write (method, subchannel, value) stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a buffer when idle |
| buf_len | input | LEN_W | Buffer length in 32-bit words, sampled with start |
| in_valid | input | 1 | Command word valid |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted when high with in_valid |
| out_valid | output | 1 | Register write valid |
| out_method | output | 13 | Method number of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_value | output | 32 | Value of the write |
| out_ready | input | 1 | Downstream accepts the write |
| busy | output | 1 | A buffer is in progress |
| done | output | 1 | One-cycle pulse: buffer finished cleanly |
| err_mode | output | 1 | One-cycle pulse: mode 6 or 7 seen |
| err_count | output | 1 | One-cycle pulse: mode 5 with zero count |
| err_trunc | output | 1 | One-cycle pulse: buffer ended inside a packet |

## Verification
Several properties are checked on every cycle by the assertions. The word budget is never overrun. The argument counter never steps past zero. A stalled write holds steady. Every terminating pulse is followed by an idle cycle, and the idle state keeps both handshakes quiet. The method sequences of each mode, the zero-extended immediate, packets with a zero count, and which of done or an error ends a buffer can only be shown by the bench. Its behavioural parser predicts every write and the outcome of each buffer under random gaps on both handshakes.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int METH_W = 13;
  localparam int SUB_W  = 3;
  localparam int CNT_W  = 13;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    MD_INC_A  = 3'd0,
    MD_INC_B  = 3'd1,
    MD_FIX_A  = 3'd2,
    MD_FIX_B  = 3'd3,
    MD_IMM    = 3'd4,
    MD_ONCE   = 3'd5,
    MD_RSV_A  = 3'd6,
    MD_RSV_B  = 3'd7
  } mode_e;

  // Field order is behaviour: bits 31:29 mode, 28:16 count, 15:13 subch, 12:0 method
  typedef struct packed {
    mode_e             mode;
    logic [CNT_W-1:0]  cnt;
    logic [SUB_W-1:0]  sub;
    logic [METH_W-1:0] meth;
  } hdr_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_ARGS = 2'd2,
    ST_IMM  = 2'd3
  } st_e;

  // Method targeted by argument number idx of a packet
  function automatic logic [METH_W-1:0] arg_method(mode_e m, logic [METH_W-1:0] base,
                                                   logic [CNT_W-1:0] idx);
    logic [METH_W-1:0] r;
    case (m)
      MD_INC_A, MD_INC_B: r = base + METH_W'(idx);
      MD_ONCE:            r = (idx == '0) ? base : base + METH_W'(1);
      default:            r = base;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o,
  output logic              bad_mode_o,
  output logic              zero_once_o,
  output logic              imm_o,
  output logic              with_args_o
);
  always_comb begin
    hdr_o       = hdr_t'(word_i);
    bad_mode_o  = (hdr_o.mode == MD_RSV_A) || (hdr_o.mode == MD_RSV_B);
    imm_o       = (hdr_o.mode == MD_IMM);
    zero_once_o = (hdr_o.mode == MD_ONCE) && (hdr_o.cnt == '0);
    with_args_o = !bad_mode_o && !imm_o && (hdr_o.cnt != '0);
  end
endmodule

// File: rtl/cmd_word_budget.sv
module cmd_word_budget #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             take_i,
  output logic             empty_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rem_q <= '0;
    else if (load_i) rem_q <= len_i;
    else if (take_i) rem_q <= rem_q - ONE;
  end

  assign empty_o = (rem_q == '0);

  // R9: no word is taken once the budget is spent
  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !empty_o);
endmodule

// File: rtl/cmd_method_seq.sv
module cmd_method_seq
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  hdr_t              hdr_i,
  input  logic              step_i,
  output logic [METH_W-1:0] method_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              last_o
);
  mode_e             mode_q;
  logic [METH_W-1:0] base_q;
  logic [SUB_W-1:0]  sub_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_INC_A;
      base_q <= '0;
      sub_q  <= '0;
      left_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      mode_q <= hdr_i.mode;
      base_q <= hdr_i.meth;
      sub_q  <= hdr_i.sub;
      left_q <= hdr_i.cnt;
      idx_q  <= '0;
    end else if (step_i) begin
      left_q <= left_q - CNT_W'(1);
      idx_q  <= idx_q + CNT_W'(1);
    end
  end

  assign method_o = arg_method(mode_q, base_q, idx_q);
  assign sub_o    = sub_q;
  assign last_o   = (left_q == CNT_W'(1));

  // R2: an argument is only taken while the packet still owes one
  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> left_q != '0);
endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
  import cmd_dec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [METH_W-1:0] out_method,
  output logic [SUB_W-1:0]  out_subch,
  output logic [WORD_W-1:0] out_value,
  input  logic              out_ready,
  output logic              busy,
  output logic              done,
  output logic              err_mode,
  output logic              err_count,
  output logic              err_trunc
);
  localparam int PAD_W = WORD_W - CNT_W;

  st_e  st_q, st_d;
  hdr_t hdr;
  logic bad_mode, zero_once, imm, with_args;
  logic word_take, hdr_take, arg_take, budget_empty, seq_last;
  logic [CNT_W-1:0] imm_q;

  cmd_hdr_decode u_dec (
    .word_i      (in_data),
    .hdr_o       (hdr),
    .bad_mode_o  (bad_mode),
    .zero_once_o (zero_once),
    .imm_o       (imm),
    .with_args_o (with_args)
  );

  assign word_take = in_valid && in_ready;
  assign hdr_take  = (st_q == ST_HEAD) && word_take;
  assign arg_take  = (st_q == ST_ARGS) && word_take;

  cmd_word_budget #(.LEN_W(LEN_W)) u_budget (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  ((st_q == ST_IDLE) && start),
    .len_i   (buf_len),
    .take_i  (word_take),
    .empty_o (budget_empty)
  );

  cmd_method_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (hdr_take),
    .hdr_i    (hdr),
    .step_i   (arg_take),
    .method_o (out_method),
    .sub_o    (out_subch),
    .last_o   (seq_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                imm_q <= '0;
    else if (hdr_take && imm)  imm_q <= hdr.cnt;
  end

  always_comb begin
    in_ready  = ((st_q == ST_HEAD) && !budget_empty) ||
                ((st_q == ST_ARGS) && !budget_empty && out_ready);
    out_valid = ((st_q == ST_ARGS) && !budget_empty && in_valid) || (st_q == ST_IMM);
    out_value = (st_q == ST_IMM) ? {{PAD_W{1'b0}}, imm_q} : in_data;
    busy      = (st_q != ST_IDLE);
    done      = (st_q == ST_HEAD) && budget_empty;
    err_trunc = (st_q == ST_ARGS) && budget_empty;
    err_mode  = hdr_take && bad_mode;
    err_count = hdr_take && zero_once;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start) st_d = ST_HEAD;
      ST_HEAD: begin
        if (budget_empty)     st_d = ST_IDLE;
        else if (hdr_take) begin
          if (bad_mode)       st_d = ST_IDLE;
          else if (imm)       st_d = ST_IMM;
          else if (with_args) st_d = ST_ARGS;
        end
      end
      ST_ARGS: begin
        if (budget_empty)             st_d = ST_IDLE;
        else if (arg_take && seq_last) st_d = ST_HEAD;
      end
      ST_IMM: if (out_ready) st_d = ST_HEAD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R11: idle keeps both handshakes quiet
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!in_ready && !out_valid && !done));

  // R12: a stalled write holds steady
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_method) &&
                                   $stable(out_subch) && $stable(out_value)));

  // R10: every terminating pulse is followed by idle
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_mode || err_trunc) |=> !busy);

  // R10: done never coincides with a terminating error
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!err_mode && !err_trunc && !out_valid));

  // R4: an immediate write is issued once and then parsing resumes
  p_imm_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IMM) && out_ready) |=> (st_q == ST_HEAD));
endmodule

// File: tb/cmd_method_decoder_test.sv
module cmd_method_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] buf_len = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [12:0] out_method;
  logic [2:0]  out_subch;
  logic [31:0] out_value;
  logic        out_ready = 1'b0;
  logic        busy, done, err_mode, err_count, err_trunc;

  always #2 clk = ~clk;  // 250 MHz

  cmd_method_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .buf_len(buf_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_method(out_method), .out_subch(out_subch),
    .out_value(out_value), .out_ready(out_ready), .busy(busy), .done(done),
    .err_mode(err_mode), .err_count(err_count), .err_trunc(err_trunc)
  );

  typedef struct { int meth; int sub; logic [31:0] val; } wr_t;
  typedef enum int { END_DONE, END_MODE, END_TRUNC } end_e;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int mode, int cnt, int sub, int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  // Behavioural parser built from the requirements
  task automatic predict(input logic [31:0] w[$], input int len, output wr_t q[$],
                         output end_e fin, output int zc);
    int pos = 0;
    q = {}; zc = 0; fin = END_DONE;
    while (pos < len) begin
      logic [31:0] h = w[pos];
      int mode = int'(h[31:29]);
      int cnt  = int'(h[28:16]);
      int sub  = int'(h[15:13]);
      int meth = int'(h[12:0]);
      pos++;
      if (mode >= 6) begin fin = END_MODE; return; end
      if (mode == 4) begin q.push_back('{meth, sub, {19'b0, h[28:16]}}); continue; end
      if (mode == 5 && cnt == 0) begin zc++; continue; end
      for (int i = 0; i < cnt; i++) begin
        int m;
        if (pos >= len) begin fin = END_TRUNC; return; end
        if (mode <= 1)      m = (meth + i) % 8192;
        else if (mode <= 3) m = meth;
        else                m = (i == 0) ? meth : (meth + 1) % 8192;
        q.push_back('{m, sub, w[pos]});
        pos++;
      end
    end
  endtask

  task automatic run_buf(input string tag, input logic [31:0] w[$], input int ready_pct);
    wr_t  q[$];
    end_e fin;
    int   zc, seen_zc = 0, idx = 0, guard = 0;
    bit   hs = 0, over = 0;
    end_e got = END_DONE;
    predict(w, w.size(), q, fin, zc);
    @(negedge clk);
    start = 1'b1; buf_len = 16'(w.size());
    while (!over) begin
      @(negedge clk);
      start = 1'b0;
      if (hs) begin idx++; in_valid = 1'b0; end
      if (!in_valid) begin
        if (idx < w.size()) begin
          in_valid = ($urandom_range(0, 3) != 0);
          in_data  = w[idx];
        end
      end
      out_ready = ($urandom_range(0, 99) < ready_pct);
      #1;
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, {tag, " unexpected write R2"}, out_method, 0);
        else begin
          wr_t e = q.pop_front();
          chk(out_method == 13'(e.meth), {tag, " method R1 R2 R3 R5"}, out_method, e.meth);
          chk(out_subch == 3'(e.sub), {tag, " subchannel R1"}, out_subch, e.sub);
          chk(out_value == e.val, {tag, " value R4"}, out_value, e.val);
        end
      end
      if (err_count) seen_zc++;
      if (done)      begin over = 1; got = END_DONE; end
      if (err_mode)  begin over = 1; got = END_MODE; end
      if (err_trunc) begin over = 1; got = END_TRUNC; end
      if (done) chk(q.size() == 0, {tag, " done after last write R10"}, q.size(), 0);
      hs = in_valid && in_ready;
      guard++;
      if (guard > 5000) begin
        chk(0, {tag, " watchdog R10"}, guard, 0);
        over = 1;
      end
    end
    chk(got == fin, {tag, " outcome R8 R9 R10"}, got, fin);
    chk(q.size() == 0, {tag, " all writes seen R6"}, q.size(), 0);
    chk(seen_zc == zc, {tag, " zero-count once R7"}, seen_zc, zc);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(!busy && !in_ready && !done, {tag, " idle after end R10 R11"}, busy, 0);
  endtask

  initial begin
    logic [31:0] b[$];
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready && !busy && !done, "reset state R11", {out_valid, in_ready, busy}, 0);
    @(negedge clk); rst_n = 1'b1;

    b = {mk(1, 3, 2, 13'h100), 32'hA, 32'hB, 32'hC};
    run_buf("inc R2", b, 80);
    b = {mk(0, 3, 5, 13'h1FFE), 32'h1, 32'h2, 32'h3};
    run_buf("inc wrap R2", b, 60);
    b = {mk(3, 3, 1, 13'h040), 32'h11, 32'h22, 32'h33, mk(2, 2, 7, 13'h7), 32'h44, 32'h55};
    run_buf("fixed R3", b, 70);
    b = {mk(4, 13'h1ABC, 6, 13'h123), mk(4, 0, 1, 13'h1FFF)};
    run_buf("inline R4", b, 50);
    b = {mk(5, 4, 3, 13'h1FFF), 32'hD0, 32'hD1, 32'hD2, 32'hD3};
    run_buf("once R5", b, 90);
    b = {mk(1, 0, 0, 13'h10), mk(3, 0, 0, 13'h20), mk(0, 1, 4, 13'h30), 32'hCAFE};
    run_buf("zero count R6", b, 80);
    b = {mk(5, 0, 2, 13'h50), mk(1, 1, 2, 13'h60), 32'hBEEF};
    run_buf("once zero R7", b, 80);
    b = {mk(1, 1, 0, 13'h5), 32'h77, mk(6, 2, 0, 13'h9), 32'h1, 32'h2};
    run_buf("mode6 R8", b, 80);
    b = {mk(7, 0, 0, 13'h9), mk(4, 5, 0, 13'h1)};
    run_buf("mode7 R8", b, 80);
    b = {mk(1, 5, 3, 13'h200), 32'h90, 32'h91};
    run_buf("trunc R9", b, 80);
    b = {};
    run_buf("empty R10", b, 80);
    b = {mk(0, 4, 1, 13'h300), 32'h5, 32'h6, 32'h7, 32'h8, mk(4, 13'h42, 2, 13'h8),
         mk(5, 2, 0, 13'h9), 32'hE1, 32'hE2};
    run_buf("stall R12", b, 15);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10: actual %0d expected 0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule